// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. A start request taken while the block is idle captures the channel number and two 4-bit reference codes. The block then runs a fixed schedule measured from that start. First comes a charge window in which the sampling capacitor tracks the selected input. Next comes a hold window in which the input is kept steady. Last come one trial clock per result bit, working from the most significant bit down. In each trial the block presents a code to an external DAC and keeps or clears the bit under test according to the comparator's answer.

The two reference codes choose the upper and lower taps of the internal reference ladder. Each has 16 steps. Narrowing the span between them spreads the 256 result codes over a smaller input range. At the end of each conversion the result register is loaded and a one-clock interrupt pulse is raised. In single mode the block then returns to idle. In continuous mode it starts the next conversion at once on the same channel. The comparator, the ladder and the capacitor live outside the block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset `busy`, `eoc_irq`, `sw_track`, `sw_hold`, `dac_code`, `result`, `mux_sel` and both tap outputs are all zero.
- R2: When `cfg_start` is high on an idle clock edge, the next cycle shows `busy`=1 and `mux_sel` equal to the `cfg_chan` value sampled at that edge. `sw_track` is then high for exactly LOAD_CYC (4) cycles.
- R3: Straight after the charge window, `sw_hold` is high and `sw_track` is low for SAMP_CYC-LOAD_CYC (4) cycles. Both are low at every other time.
- R4: Then come RES_W (8) trial cycles. In trial k (k=0 is first), `dac_code` equals the bits already kept plus bit 7-k set. That bit is kept exactly when `cmp_above` is 1 in that cycle. Outside trial cycles `dac_code` is 0. With a valid span the final code is the largest code whose ladder level does not exceed the input.
- R5: In single mode `busy` lasts exactly 16 cycles. `eoc_irq` is high for exactly one cycle: the first cycle after the last trial, which is also the first cycle with `busy`=0.
- R6: `result` changes only in a cycle where `eoc_irq` is high. It then holds the code decided by that conversion.
- R7: If `cfg_cont` is 1 at the last trial, the cycle that carries `eoc_irq` is already the first charge cycle of the next conversion (`busy`=1, `sw_track`=1). `mux_sel` keeps the channel captured at the original start, whatever `cfg_chan` does later.
- R8: `cfg_start` while `busy` is high is ignored. The running schedule neither restarts nor stretches.
- R9: `ref_hi_tap` and `ref_lo_tap` take `cfg_ref_hi` and `cfg_ref_lo` at the accepted start. They then stay constant while `busy` stays high, including across continuous restarts.
- R10: If the captured upper code is not greater than the captured lower code, `result` is forced to 0 at the end of the conversion. `eoc_irq` is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chan | input | 3 | Channel number sampled at start |
| cfg_cont | input | 1 | 1 = continuous, sampled at each last trial |
| cfg_start | input | 1 | Start request, honoured only when idle |
| cfg_ref_hi | input | 4 | Upper reference tap code |
| cfg_ref_lo | input | 4 | Lower reference tap code |
| cmp_above | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| mux_sel | output | 3 | Analog multiplexer select |
| sw_track | output | 1 | Sample switch closed (charge window) |
| sw_hold | output | 1 | Input held steady (rest of sample window) |
| ref_hi_tap | output | 4 | Upper ladder tap in use |
| ref_lo_tap | output | 4 | Lower ladder tap in use |
| dac_code | output | 8 | Trial code for the DAC |
| result | output | 8 | Last conversion result |
| busy | output | 1 | Conversion in progress |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench builds the block with its defaults: 8 result bits, eight channels, 4-bit tap codes, a 4-clock charge window and an 8-clock sample window. A conversion therefore lasts only 16 clocks, so a short run can cover many cases. These include full-scale and zero-scale results, an input exactly on a ladder level, inputs outside a narrowed span, both kinds of degenerate span, and a three-conversion continuous run with the channel and mode changing around it. The analog side is an integer ladder model driven from the block's own tap, channel and DAC outputs.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_TRIAL = 2'd3
  } sar_phase_e;
endpackage

// File: rtl/sar_seq_timer.sv
// Phase sequencer: idle -> charge -> hold -> bit trials -> idle or charge.
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int LOAD_CYC = 4,
  parameter int SAMP_CYC = 8,
  parameter int RES_W    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cont,
  output sar_phase_e phase,
  output logic       launch,
  output logic       step,
  output logic       last
);
  localparam int HOLD_CYC = SAMP_CYC - LOAD_CYC;
  localparam int MAX_A    = (LOAD_CYC > HOLD_CYC) ? LOAD_CYC : HOLD_CYC;
  localparam int MAX_C    = (MAX_A > RES_W) ? MAX_A : RES_W;
  localparam int CNT_W    = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TRIAL_LAST = CNT_W'(RES_W - 1);

  logic [CNT_W-1:0] cnt;

  assign launch = (phase == PH_IDLE) && start;
  assign step   = (phase == PH_TRIAL);
  assign last   = step && (cnt == TRIAL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= PH_LOAD;
        end
        PH_LOAD: begin
          if (cnt == LOAD_LAST) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == HOLD_LAST) begin
            phase <= PH_TRIAL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TRIAL: begin
          if (cnt == TRIAL_LAST) begin
            phase <= cont ? PH_LOAD : PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R2: the charge window advances one count per clock and is never cut short.
  p_load_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && cnt != LOAD_LAST) |=> (phase == PH_LOAD && cnt == $past(cnt) + 1'b1));

  // R3: the hold window follows the charge window directly.
  p_hold_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && cnt == LOAD_LAST) |=> (phase == PH_HOLD && cnt == '0));

  // R4: trials begin right after the hold window ends.
  p_trial_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && cnt == HOLD_LAST) |=> (phase == PH_TRIAL && cnt == '0));

  // R8: a running conversion only leaves the busy phases after its last trial.
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !last) |=> (phase != PH_IDLE && !(phase == PH_LOAD && cnt == '0)));
endmodule

// File: rtl/sar_seq_sar.sv
// Successive-approximation register with a rotating one-hot trial mask.
module sar_seq_sar #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             cmp,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] next_code
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] mask;

  assign trial_code = acc | mask;
  assign next_code  = cmp ? (acc | mask) : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      mask <= MSB_ONLY;
    end else if (clear) begin
      acc  <= '0;
      mask <= MSB_ONLY;
    end else if (step) begin
      acc  <= next_code;
      mask <= {mask[0], mask[RES_W-1:1]};
    end
  end

  // R4: exactly one bit under test at all times.
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(mask) == 1);

  // R4: every conversion starts testing at the most significant bit with nothing kept.
  p_clear_msb_r4: assert property (@(posedge clk) disable iff (rst)
    clear |=> (mask == MSB_ONLY && acc == '0));

  // R4: a comparator high keeps the tested bit, a low drops it.
  p_bit_decide_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (((acc & $past(mask)) != '0) == $past(cmp)));
endmodule

// File: rtl/sar_seq_cfg.sv
// Captures channel and ladder taps when a conversion is launched.
module sar_seq_cfg #(
  parameter int CH_W  = 3,
  parameter int REF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CH_W-1:0]  chan_in,
  input  logic [REF_W-1:0] hi_in,
  input  logic [REF_W-1:0] lo_in,
  output logic [CH_W-1:0]  chan_q,
  output logic [REF_W-1:0] hi_q,
  output logic [REF_W-1:0] lo_q,
  output logic             span_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      span_ok <= 1'b0;
    end else if (capture) begin
      chan_q  <= chan_in;
      hi_q    <= hi_in;
      lo_q    <= lo_in;
      span_ok <= (hi_in > lo_in);
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W    = 8,
  parameter int CH_N     = 8,
  parameter int REF_W    = 4,
  parameter int LOAD_CYC = 4,
  parameter int SAMP_CYC = 8,
  localparam int CH_W    = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_cont,
  input  logic             cfg_start,
  input  logic [REF_W-1:0] cfg_ref_hi,
  input  logic [REF_W-1:0] cfg_ref_lo,
  input  logic             cmp_above,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sw_track,
  output logic             sw_hold,
  output logic [REF_W-1:0] ref_hi_tap,
  output logic [REF_W-1:0] ref_lo_tap,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             eoc_irq
);
  sar_phase_e       phase;
  logic             launch;
  logic             step;
  logic             last;
  logic             clear;
  logic             span_ok;
  logic [RES_W-1:0] trial_code;
  logic [RES_W-1:0] next_code;

  sar_seq_timer #(
    .LOAD_CYC(LOAD_CYC),
    .SAMP_CYC(SAMP_CYC),
    .RES_W   (RES_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (cfg_start),
    .cont  (cfg_cont),
    .phase (phase),
    .launch(launch),
    .step  (step),
    .last  (last)
  );

  assign clear = launch | (last & cfg_cont);

  sar_seq_sar #(
    .RES_W(RES_W)
  ) u_sar (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .step      (step),
    .cmp       (cmp_above),
    .trial_code(trial_code),
    .next_code (next_code)
  );

  sar_seq_cfg #(
    .CH_W (CH_W),
    .REF_W(REF_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .capture(launch),
    .chan_in(cfg_chan),
    .hi_in  (cfg_ref_hi),
    .lo_in  (cfg_ref_lo),
    .chan_q (mux_sel),
    .hi_q   (ref_hi_tap),
    .lo_q   (ref_lo_tap),
    .span_ok(span_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      eoc_irq <= 1'b0;
    end else begin
      eoc_irq <= last;
      if (last) result <= span_ok ? next_code : '0;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign sw_track = (phase == PH_LOAD);
  assign sw_hold  = (phase == PH_HOLD);
  assign dac_code = step ? trial_code : '0;

  // R5: the end-of-conversion pulse never lasts two cycles.
  p_eoc_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |=> !eoc_irq);

  // R5: busy only drops together with the end-of-conversion pulse.
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> eoc_irq);

  // R6: the result register moves only with the pulse.
  p_result_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> eoc_irq);

  // R7: the channel is held for as long as the block stays busy.
  p_chan_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mux_sel));

  // R9: ladder taps are held for as long as the block stays busy.
  p_taps_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(ref_hi_tap) && $stable(ref_lo_tap)));

  // R10: an empty or inverted span yields a zero result.
  p_zero_span_r10: assert property (@(posedge clk) disable iff (rst)
    (eoc_irq && !(ref_hi_tap > ref_lo_tap)) |-> (result == '0));

  // R3: the charge and hold controls never overlap.
  p_sw_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(sw_track && sw_hold));
endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
  localparam int RES_W = 8;
  localparam int CH_N  = 8;
  localparam int REF_W = 4;
  localparam int LOADC = 4;
  localparam int SAMPC = 8;
  localparam int FULL  = 1 << RES_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_chan = '0;
  logic       cfg_cont = 1'b0;
  logic       cfg_start = 1'b0;
  logic [3:0] cfg_ref_hi = '0;
  logic [3:0] cfg_ref_lo = '0;
  logic       cmp_above;
  logic [2:0] mux_sel;
  logic       sw_track, sw_hold, busy, eoc_irq;
  logic [3:0] ref_hi_tap, ref_lo_tap;
  logic [7:0] dac_code, result;

  int vin [CH_N];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sar_seq_ctrl #(
    .RES_W(RES_W), .CH_N(CH_N), .REF_W(REF_W), .LOAD_CYC(LOADC), .SAMP_CYC(SAMPC)
  ) u_sar_seq_ctrl (
    .clk(clk), .rst(rst), .cfg_chan(cfg_chan), .cfg_cont(cfg_cont), .cfg_start(cfg_start),
    .cfg_ref_hi(cfg_ref_hi), .cfg_ref_lo(cfg_ref_lo), .cmp_above(cmp_above),
    .mux_sel(mux_sel), .sw_track(sw_track), .sw_hold(sw_hold),
    .ref_hi_tap(ref_hi_tap), .ref_lo_tap(ref_lo_tap), .dac_code(dac_code),
    .result(result), .busy(busy), .eoc_irq(eoc_irq)
  );

  // Ladder level of a code: lower tap plus code times the tap span (units of FULL per step).
  function automatic int level(int lo, int hi, int d);
    return lo * FULL + d * (hi - lo);
  endfunction

  function automatic int ideal(int v, int lo, int hi);
    int q;
    if (hi <= lo) return 0;
    if (v < lo * FULL) return 0;
    q = (v - lo * FULL) / (hi - lo);
    if (q > FULL - 1) q = FULL - 1;
    return q;
  endfunction

  // Analog side: comparator driven from the block's own outputs.
  always_comb cmp_above = (vin[mux_sel] >= level(int'(ref_lo_tap), int'(ref_hi_tap), int'(dac_code)));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference model, advanced at each rising edge.
  int m_t = -1, m_sar = 0, m_res = 0, m_eoc = 0, m_chan = 0, m_hi = 0, m_lo = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_t = -1; m_sar = 0; m_res = 0; m_eoc = 0; m_chan = 0; m_hi = 0; m_lo = 0;
    end else begin
      m_eoc = 0;
      if (m_t < 0) begin
        if (cfg_start) begin
          m_t = 0; m_sar = 0;
          m_chan = int'(cfg_chan); m_hi = int'(cfg_ref_hi); m_lo = int'(cfg_ref_lo);
        end
      end else if (m_t < SAMPC) begin
        m_t++;
      end else begin
        int bp;
        int d;
        bp = RES_W - 1 - (m_t - SAMPC);
        d = m_sar | (1 << bp);
        if (vin[m_chan] >= level(m_lo, m_hi, d)) m_sar = d;
        if (bp == 0) begin
          m_res = (m_hi > m_lo) ? m_sar : 0;
          m_eoc = 1;
          if (cfg_cont) begin m_t = 0; m_sar = 0; end
          else m_t = -1;
        end else begin
          m_t++;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      int e_dac;
      e_dac = (m_t >= SAMPC) ? (m_sar | (1 << (RES_W - 1 - (m_t - SAMPC)))) : 0;
      chk(busy == (m_t >= 0), "R5 busy", int'(busy), int'(m_t >= 0));
      chk(eoc_irq == m_eoc[0], "R5 eoc_irq", int'(eoc_irq), m_eoc);
      chk(sw_track == (m_t >= 0 && m_t < LOADC), "R2 sw_track", int'(sw_track), int'(m_t >= 0 && m_t < LOADC));
      chk(sw_hold == (m_t >= LOADC && m_t < SAMPC), "R3 sw_hold", int'(sw_hold), int'(m_t >= LOADC && m_t < SAMPC));
      chk(int'(dac_code) == e_dac, "R4 dac_code", int'(dac_code), e_dac);
      chk(int'(result) == m_res, "R6 result", int'(result), m_res);
      chk(int'(mux_sel) == m_chan, "R7 mux_sel", int'(mux_sel), m_chan);
      chk(int'(ref_hi_tap) == m_hi && int'(ref_lo_tap) == m_lo, "R9 taps",
          int'(ref_hi_tap) * 16 + int'(ref_lo_tap), m_hi * 16 + m_lo);
    end
  end

  task automatic go(int ch, int hi, int lo, bit cont);
    @(negedge clk);
    cfg_chan = 3'(ch); cfg_ref_hi = 4'(hi); cfg_ref_lo = 4'(lo); cfg_cont = cont; cfg_start = 1'b1;
  endtask

  // Waits for the pulse; counts busy cycles seen before it. Optional pokes while running.
  task automatic wait_eoc(output int nbusy, input bit poke_start, input bit scramble);
    nbusy = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cfg_start = poke_start && (i < 10);
      if (scramble) begin
        cfg_ref_hi = 4'(i); cfg_ref_lo = 4'(15 - i); cfg_chan = 3'(i);
      end
      if (eoc_irq) return;
      if (busy) nbusy++;
    end
    chk(1'b0, "R5 no end-of-conversion pulse", 0, 1);
  endtask

  task automatic single(int ch, int hi, int lo, bit poke, bit scr, string tag);
    int nb;
    int e;
    e = ideal(vin[ch], lo, hi);
    go(ch, hi, lo, 1'b0);
    wait_eoc(nb, poke, scr);
    chk(nb == 16, {tag, " R5 busy length"}, nb, 16);
    chk(int'(result) == e, {tag, " result vs ideal"}, int'(result), e);
    chk(busy == 1'b0, {tag, " R5 idle at pulse"}, int'(busy), 0);
    @(negedge clk);
    chk(eoc_irq == 1'b0, {tag, " R5 pulse one cycle"}, int'(eoc_irq), 0);
  endtask

  initial begin
    int nb;
    vin[0] = 0;    vin[1] = 5000; vin[2] = 100;  vin[3] = 1000;
    vin[4] = 1700; vin[5] = 1668; vin[6] = 2000; vin[7] = 3840;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy == 0 && eoc_irq == 0, "R1 busy/eoc", int'(busy) * 2 + int'(eoc_irq), 0);
    chk(sw_track == 0 && sw_hold == 0, "R1 switches", int'(sw_track) * 2 + int'(sw_hold), 0);
    chk(dac_code == 0 && result == 0, "R1 codes", int'(dac_code) + int'(result), 0);
    chk(mux_sel == 0 && ref_hi_tap == 0 && ref_lo_tap == 0, "R1 select/taps",
        int'(mux_sel) + int'(ref_hi_tap) + int'(ref_lo_tap), 0);

    single(3, 15, 0, 1'b0, 1'b0, "R4 mid input");
    single(0, 15, 0, 1'b0, 1'b0, "R4 zero input");
    single(7, 15, 0, 1'b0, 1'b0, "R4 full scale");
    single(3, 15, 0, 1'b1, 1'b0, "R8 start while busy");
    single(4, 9, 5, 1'b0, 1'b1, "R9 narrow span, inputs scrambled");
    single(1, 9, 5, 1'b0, 1'b0, "R4 above span");
    single(2, 9, 5, 1'b0, 1'b0, "R4 below span");
    single(5, 12, 3, 1'b0, 1'b0, "R4 exactly on level");
    single(6, 4, 4, 1'b0, 1'b0, "R10 equal taps");
    single(6, 2, 7, 1'b0, 1'b0, "R10 inverted taps");
    single(3, 15, 0, 1'b0, 1'b0, "R6 result after zero");

    // R7: continuous run on channel 6, select input moved after start
    go(6, 12, 3, 1'b1);
    @(negedge clk);
    cfg_start = 1'b0; cfg_chan = 3'd1;
    wait_eoc(nb, 1'b0, 1'b0);
    chk(int'(result) == ideal(2000, 3, 12), "R7 first result", int'(result), ideal(2000, 3, 12));
    chk(busy && sw_track && mux_sel == 3'd6, "R7 restart at pulse", int'(busy) * 2 + int'(sw_track), 3);
    vin[6] = 1500;
    wait_eoc(nb, 1'b0, 1'b0);
    chk(int'(result) == ideal(1500, 3, 12), "R7 second result", int'(result), ideal(1500, 3, 12));
    chk(busy && sw_track && mux_sel == 3'd6, "R7 second restart", int'(busy) * 2 + int'(sw_track), 3);
    vin[6] = 3000;
    cfg_cont = 1'b0;
    wait_eoc(nb, 1'b0, 1'b0);
    chk(int'(result) == ideal(3000, 3, 12), "R7 third result", int'(result), ideal(3000, 3, 12));
    chk(busy == 1'b0, "R7 stops when mode cleared", int'(busy), 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule